// File: doc/BRIEF.md
# Interrupt Aggregator With Bus-Write Delivery

The block gathers 32 level-sampled interrupt lines into one set of 32-bit registers that software reaches over a simple register port. Every clock edge that sees a line high records it in a pending register. If the line is also enabled in the mask register, it is recorded in a request register as well. Unless the control register's bus-error bit is set, the block then tells the processor by acting as a bus master and issuing one 32-bit write on a request/acknowledge port.

The target of that write comes from a programmable address register. The address is that register with its low five bits forced to zero, and the data is those five low bits, zero-extended. Enabled interrupts that arrive while a write still waits for acknowledge are merged into one further write. That write starts only after the acknowledge, and it takes its address and data from the address register as it stands when it starts. A power control register turns a specific written code into a one-cycle power-off pulse.

Top module: `irq_deliver_hub`

## Requirements
- R1: A clock edge that samples `irq_i[n]` high sets pending bit n (register offset 0x08) whatever the mask holds. A low line clears nothing.
- R2: A clock edge that samples `irq_i[n]` high while mask bit n (offset 0x04, read/write) is set also sets request bit n (offset 0x00). The request register is read-only: writes to it leave it unchanged, and its bits stay set until reset.
- R3: An edge that samples an enabled line high, while the bus-error bit is clear, raises `wr_req_o` from the next cycle on. `wr_addr_o` is then the address register (offset 0x10) with bits [4:0] cleared, and `wr_data_o` is its bits [4:0] zero-extended, with `wr_data_o[31:24]` the byte for the lowest address (big-endian). Request, address and data hold until the edge that samples `wr_ack_i` high.
- R4: While control bit 0 (bus error, offset 0x0C) is set, enabled interrupts still set request bits but start no write. A read of the control register returns only bit 0, and all other bits read zero.
- R5: Enabled interrupts sampled while a write is outstanding cause exactly one further write, however many arrive. `wr_req_o` is low in the cycle after the acknowledge, and the further write then uses the address register value current at its start.
- R6: Any access to the pending register, read or write, clears it at that edge. A read returns the value before clearing, and a line sampled high at that same edge stays set.
- R7: After reset the address register reads 0xFFFB0003, and request, mask, pending and control read zero.
- R8: A write of 0x00000002 to offset 0x14 drives `pwr_off_o` high for exactly one cycle, starting the cycle after the write edge. Any other value written there does nothing. Offsets 0x14 and 0x18 always read zero.
- R9: Offsets other than 0x00 to 0x18 read zero, and writes to them, or to offset 0x18, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 32 | Interrupt lines, sampled every edge |
| reg_valid_i | input | 1 | Register access strobe, one access per cycle |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as the read strobe |
| wr_req_o | output | 1 | Delivery write request |
| wr_addr_o | output | 32 | Delivery write address, 32-byte aligned |
| wr_data_o | output | 32 | Delivery write data |
| wr_ack_i | input | 1 | Delivery write acknowledge |
| pwr_off_o | output | 1 | One-cycle power-off request |

## Verification
Register reads are combinational, so the bench samples `reg_rdata_o` in the access cycle, before the edge that applies any clear. A pending or request bit is due one edge after the line was driven, and `wr_req_o` is checked in the cycle right after the interrupt edge. `pwr_off_o` is counted at the falling edge after the power write. The scoreboard holds each predicted delivery write as an address/data pair. The monitor pops it when `wr_req_o` first appears, returns the acknowledge after a set delay, and checks that `wr_req_o` is low one cycle later, so both merging and the gap after acknowledge are timed to the cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned OFS_REQ  = 'h00;
  localparam int unsigned OFS_MASK = 'h04;
  localparam int unsigned OFS_PEND = 'h08;
  localparam int unsigned OFS_CTRL = 'h0C;
  localparam int unsigned OFS_ADDR = 'h10;
  localparam int unsigned OFS_PWR  = 'h14;
  localparam int unsigned OFS_VER  = 'h18;

  localparam logic [31:0] ADDR_RST  = 32'hFFFB_0003;
  localparam logic [31:0] PWR_CODE  = 32'h0000_0002;
  localparam int unsigned BERR_BIT  = 0;

  typedef enum logic {
    DLV_IDLE = 1'b0,
    DLV_BUSY = 1'b1
  } dlv_state_e;
endpackage

// File: rtl/irqd_capture.sv
module irqd_capture #(
  parameter int unsigned N_IRQ = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic             pend_clr_i,
  output logic [N_IRQ-1:0] pend_o,
  output logic [N_IRQ-1:0] req_o,
  output logic             hit_o
);
  logic [N_IRQ-1:0] pend_q, req_q;
  logic [N_IRQ-1:0] en_irq;

  assign en_irq = irq_i & mask_i;
  assign hit_o  = |en_irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      req_q  <= '0;
    end else begin
      // a set in the clearing cycle survives
      pend_q <= (pend_clr_i ? '0 : pend_q) | irq_i;
      req_q  <= req_q | en_irq;
    end
  end

  assign pend_o = pend_q;
  assign req_o  = req_q;

  assert_pend_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i != '0) |=> ((pend_q & $past(irq_i)) == $past(irq_i)));

  assert_req_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_irq != '0) |=> ((req_q & $past(en_irq)) == $past(en_irq)));

  assert_req_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q != '0) |=> ((req_q & $past(req_q)) == $past(req_q)));

  assert_pend_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_clr_i |=> (pend_q == $past(irq_i)));
endmodule

// File: rtl/irqd_regs.sv
module irqd_regs #(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_valid_i,
  input  logic             reg_write_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] req_i,
  output logic             pend_clr_o,
  output logic [N_IRQ-1:0] mask_o,
  output logic             berr_o,
  output logic [DW-1:0]    addr_o,
  output logic             pwr_off_o
);
  import irqd_pkg::*;

  logic [N_IRQ-1:0] mask_q;
  logic [DW-1:0]    ctrl_q, addr_q;
  logic             pwr_q;
  logic             wr_en, rd_en;
  logic             sel_req, sel_mask, sel_pend, sel_ctrl, sel_addr, sel_pwr;
  logic [DW-1:0]    pend_w, req_w, mask_w, ctrl_w, rd_val;

  assign wr_en = reg_valid_i &  reg_write_i;
  assign rd_en = reg_valid_i & ~reg_write_i;

  assign sel_req  = (reg_addr_i == AW'(OFS_REQ));
  assign sel_mask = (reg_addr_i == AW'(OFS_MASK));
  assign sel_pend = (reg_addr_i == AW'(OFS_PEND));
  assign sel_ctrl = (reg_addr_i == AW'(OFS_CTRL));
  assign sel_addr = (reg_addr_i == AW'(OFS_ADDR));
  assign sel_pwr  = (reg_addr_i == AW'(OFS_PWR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ctrl_q <= '0;
      addr_q <= DW'(ADDR_RST);
      pwr_q  <= 1'b0;
    end else begin
      pwr_q <= wr_en && sel_pwr && (reg_wdata_i == DW'(PWR_CODE));
      if (wr_en && sel_mask) mask_q <= reg_wdata_i[N_IRQ-1:0];
      if (wr_en && sel_ctrl) ctrl_q <= reg_wdata_i;
      if (wr_en && sel_addr) addr_q <= reg_wdata_i;
    end
  end

  always_comb begin
    pend_w = '0;
    req_w  = '0;
    mask_w = '0;
    ctrl_w = '0;
    pend_w[N_IRQ-1:0] = pend_i;
    req_w[N_IRQ-1:0]  = req_i;
    mask_w[N_IRQ-1:0] = mask_q;
    ctrl_w[BERR_BIT]  = ctrl_q[BERR_BIT];
  end

  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      sel_req:  rd_val = req_w;
      sel_mask: rd_val = mask_w;
      sel_pend: rd_val = pend_w;
      sel_ctrl: rd_val = ctrl_w;
      sel_addr: rd_val = addr_q;
      default:  rd_val = '0;
    endcase
  end

  assign reg_rdata_o = rd_en ? rd_val : '0;
  assign pend_clr_o  = reg_valid_i && sel_pend;
  assign mask_o      = mask_q;
  assign berr_o      = ctrl_q[BERR_BIT];
  assign addr_o      = addr_q;
  assign pwr_off_o   = pwr_q;

  assert_ctrl_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && sel_ctrl) |-> ((reg_rdata_o & ~(DW'(1) << BERR_BIT)) == '0));

  assert_addr_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && sel_addr) |=> $stable(addr_q));
endmodule

// File: rtl/irqd_deliver.sv
module irqd_deliver #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LOW_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [DW-1:0] addr_i,
  output logic          wr_req_o,
  output logic [DW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i
);
  import irqd_pkg::*;

  dlv_state_e    state_q;
  logic          queued_q;
  logic [DW-1:0] addr_q, data_q;
  logic          start;

  assign start = (state_q == DLV_IDLE) && (fire_i || queued_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= DLV_IDLE;
      queued_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      if (start) begin
        state_q  <= DLV_BUSY;
        queued_q <= 1'b0;
        addr_q   <= {addr_i[DW-1:LOW_W], {LOW_W{1'b0}}};
        data_q   <= DW'(addr_i[LOW_W-1:0]);
      end else if (state_q == DLV_BUSY) begin
        // merge arrivals into one follow-up write
        queued_q <= queued_q | fire_i;
        if (wr_ack_i) state_q <= DLV_IDLE;
      end
    end
  end

  assign wr_req_o  = (state_q == DLV_BUSY);
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  assert_addr_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (wr_addr_o[LOW_W-1:0] == '0));

  assert_gap_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ack_i) |=> !wr_req_o);
endmodule

// File: rtl/irq_deliver_hub.sv
module irq_deliver_hub #(
  parameter int unsigned N_IRQ = 32,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned LOW_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             reg_valid_i,
  input  logic             reg_write_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             wr_req_o,
  output logic [DW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o,
  input  logic             wr_ack_i,
  output logic             pwr_off_o
);
  logic [N_IRQ-1:0] pend, req, mask;
  logic             pend_clr, hit, berr, fire;
  logic [DW-1:0]    dlv_addr;

  irqd_capture #(.N_IRQ(N_IRQ)) i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .mask_i     (mask),
    .pend_clr_i (pend_clr),
    .pend_o     (pend),
    .req_o      (req),
    .hit_o      (hit)
  );

  irqd_regs #(.N_IRQ(N_IRQ), .AW(AW), .DW(DW)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_valid_i (reg_valid_i),
    .reg_write_i (reg_write_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .pend_i      (pend),
    .req_i       (req),
    .pend_clr_o  (pend_clr),
    .mask_o      (mask),
    .berr_o      (berr),
    .addr_o      (dlv_addr),
    .pwr_off_o   (pwr_off_o)
  );

  assign fire = hit && !berr;

  irqd_deliver #(.DW(DW), .LOW_W(LOW_W)) i_deliver (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .addr_i    (dlv_addr),
    .wr_req_o  (wr_req_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .wr_ack_i  (wr_ack_i)
  );

  assert_berr_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_req_o && berr && !fire) |=> (!wr_req_o || $past(i_deliver.queued_q)));
endmodule

// File: tb/test_irq_deliver_hub.sv
module test_irq_deliver_hub;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        reg_valid_i = 1'b0, reg_write_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        wr_req_o, wr_ack_i = 1'b0, pwr_off_o;
  logic [31:0] wr_addr_o, wr_data_o;

  int checks = 0, errors = 0;
  int ack_delay = 2, wait_cnt = 0, pwr_cnt = 0;
  bit done = 0;
  logic [63:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  irq_deliver_hub i_irq_deliver_hub (
    .clk_i, .rst_ni, .irq_i, .reg_valid_i, .reg_write_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .wr_req_o, .wr_addr_o, .wr_data_o,
    .wr_ack_i, .pwr_off_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_valid_i = 0; reg_write_i = 0;
  endtask

  task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 0; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_valid_i = 0;
  endtask

  task automatic pulse(logic [31:0] v);
    @(negedge clk_i);
    irq_i = v;
    @(negedge clk_i);
    irq_i = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && !wr_req_o && !wr_ack_i) break;
    end
    repeat (3) @(negedge clk_i);
  endtask

  // scoreboard monitor and acknowledge responder
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (wr_ack_i) begin
        wr_ack_i = 0;
        wait_cnt = 0;
        #1 chk("R5 req low after ack", {31'b0, wr_req_o}, 32'h0);
      end else if (wr_req_o) begin
        if (wait_cnt == 0) begin
          if (exp_q.size() == 0) begin
            chk("R4/R5 unexpected delivery", wr_addr_o, 32'hxxxx_xxxx);
          end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk("R3 delivery address", wr_addr_o, e[63:32]);
            chk("R3 delivery data", wr_data_o, e[31:0]);
          end
        end
        wait_cnt++;
        if (wait_cnt > ack_delay) wr_ack_i = 1;
      end
    end
  end

  always @(negedge clk_i) if (pwr_off_o) pwr_cnt++;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R7, R8, R9 reset values and fixed-zero offsets
    reg_rd(8'h00, d); chk("R7 request reset", d, 32'h0);
    reg_rd(8'h04, d); chk("R7 mask reset", d, 32'h0);
    reg_rd(8'h08, d); chk("R7 pending reset", d, 32'h0);
    reg_rd(8'h0C, d); chk("R7 control reset", d, 32'h0);
    reg_rd(8'h10, d); chk("R7 address reset", d, 32'hFFFB_0003);
    reg_rd(8'h14, d); chk("R8 power reads zero", d, 32'h0);
    reg_rd(8'h18, d); chk("R8 version reads zero", d, 32'h0);
    reg_rd(8'h1C, d); chk("R9 unmapped reads zero", d, 32'h0);

    // R1 pending without mask, no delivery; R6 clear on read
    pulse(32'h0000_0001);
    repeat (2) @(negedge clk_i);
    reg_rd(8'h08, d); chk("R1 pending set unmasked, sticky", d, 32'h1);
    reg_rd(8'h08, d); chk("R6 pending cleared by read", d, 32'h0);
    reg_rd(8'h00, d); chk("R2 request not set when masked off", d, 32'h0);

    // R3 delivery
    reg_wr(8'h04, 32'h0000_00F0);
    reg_wr(8'h10, 32'h1234_5677);
    reg_rd(8'h04, d); chk("R2 mask read back", d, 32'h0000_00F0);
    ack_delay = 3;
    exp_q.push_back({32'h1234_5660, 32'h0000_0017});
    pulse(32'h0000_0010);
    chk("R3 request due cycle after edge", {31'b0, wr_req_o}, 32'h1);
    wait_idle();
    reg_rd(8'h00, d); chk("R2 request bit set", d, 32'h0000_0010);

    // R5 merge: several arrivals while busy -> one more write, new address
    ack_delay = 12;
    exp_q.push_back({32'h1234_5660, 32'h0000_0017});
    exp_q.push_back({32'h0000_0040, 32'h0000_0001});
    pulse(32'h0000_0020);
    pulse(32'h0000_0040);
    reg_wr(8'h10, 32'h0000_0041);
    pulse(32'h0000_0080);
    wait_idle();
    repeat (5) @(negedge clk_i);
    chk("R5 merged into exactly two writes", exp_q.size(), 32'h0);
    reg_rd(8'h00, d); chk("R2 request accumulates", d, 32'h0000_00F0);
    ack_delay = 2;

    // R4 bus-error suppresses delivery
    reg_wr(8'h0C, 32'hFFFF_FFFF);
    reg_rd(8'h0C, d); chk("R4 control reads bit0 only", d, 32'h1);
    reg_wr(8'h00, 32'h0);
    reg_rd(8'h00, d); chk("R2 request write ignored", d, 32'h0000_00F0);
    reg_rd(8'h08, d);
    pulse(32'h0000_0010);
    repeat (6) @(negedge clk_i);
    chk("R4 no delivery under bus error", {31'b0, wr_req_o}, 32'h0);
    reg_rd(8'h08, d); chk("R4 pending still set", d, 32'h0000_0010);
    reg_wr(8'h0C, 32'h0);

    // R6 write clears; set in clearing cycle wins
    pulse(32'h0000_0004);
    reg_wr(8'h08, 32'h1234_5678);
    reg_rd(8'h08, d); chk("R6 pending cleared by write", d, 32'h0);
    pulse(32'h0000_0001);
    @(negedge clk_i);
    reg_valid_i = 1; reg_write_i = 0; reg_addr_i = 8'h08; irq_i = 32'h0000_0002;
    #1 d = reg_rdata_o;
    chk("R6 read returns prior value", d, 32'h1);
    @(negedge clk_i);
    reg_valid_i = 0; irq_i = '0;
    reg_rd(8'h08, d); chk("R6 same-cycle set survives", d, 32'h2);

    // R8 power control
    pwr_cnt = 0;
    reg_wr(8'h14, 32'h0000_0003);
    repeat (2) @(negedge clk_i);
    chk("R8 other value no pulse", pwr_cnt, 32'h0);
    reg_wr(8'h14, 32'h0000_0002);
    chk("R8 pulse due after write edge", {31'b0, pwr_off_o}, 32'h1);
    repeat (3) @(negedge clk_i);
    chk("R8 pulse exactly one cycle", pwr_cnt, 32'h1);

    // R9 writes to version and unmapped offsets change nothing
    reg_wr(8'h18, 32'hFFFF_FFFF);
    reg_wr(8'h1C, 32'hFFFF_FFFF);
    reg_wr(8'h40, 32'hFFFF_FFFF);
    reg_rd(8'h18, d); chk("R9 version write ignored", d, 32'h0);
    reg_rd(8'h10, d); chk("R9 address untouched", d, 32'h0000_0041);
    reg_rd(8'h04, d); chk("R9 mask untouched", d, 32'h0000_00F0);
    reg_rd(8'h0C, d); chk("R9 control untouched", d, 32'h0);

    wait_idle();
    chk("R3 scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule